// File: doc/BRIEF.md
# Direction Reversal Guard

This block decides when a change of rotation direction may reach the commutation logic of a brushless motor drive. An asynchronous direction request is first brought into the clock domain, then captured by a gated holding stage that only accepts a new value while an external speed comparator reports that the motor is slow. The accepted value is then moved through a short shift chain that advances only on the PWM oscillator tick. The last stage of that chain is the committed direction used by the commutation decoder.

While any stage of the path disagrees with the stage after it, the block raises a drive-inhibit signal so that the power stage coasts instead of fighting the motor. Because the chain moves only on PWM ticks, a reversal can never reach the decoder in less than one PWM period, which provides dead time between the old and new drive patterns. Every toggle of the sampled direction also raises a one-cycle tachometer pulse request, whatever the speed.

Top module: `dir_reversal_guard`

## Requirements
- R1: The direction input passes through a two-flop synchronizer: a change on `dir_req` becomes visible to the rest of the block two clock edges after it is applied.
- R2: While `speed_hi` is 0, the holding stage copies the synchronized direction on every clock edge.
- R3: While `speed_hi` is 1, the holding stage keeps its value and a direction change is not passed on; the committed direction stays unchanged.
- R4: The two-stage shift chain advances only on clock edges where `pwm_tick` is 1; `dir_commit` (1 = reverse, 0 = forward) changes on the second tick edge after the holding stage takes a new value, and never on any other edge.
- R5: `drive_inhibit` is 1 whenever the synchronized direction differs from the holding stage.
- R6: `drive_inhibit` is 1 whenever the holding stage differs from the first chain stage or the first chain stage differs from the second.
- R7: `drive_inhibit` is 0 when the synchronized direction, the holding stage and both chain stages all agree.
- R8: `tach_req` is 1 for exactly one clock cycle for every toggle of the synchronized direction, in the same cycle the synchronized direction changes, regardless of `speed_hi`.
- R9: While `rst_n` is 0 (synchronous, active low), the holding stage, both chain stages and the edge detector take the synchronized direction, so after release `drive_inhibit` and `tach_req` are 0 and `dir_commit` equals the held input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dir_req | input | 1 | Asynchronous direction request, 1 = reverse |
| speed_hi | input | 1 | Speed above threshold flag from external comparator |
| pwm_tick | input | 1 | One-cycle strobe per PWM oscillator period |
| dir_commit | output | 1 | Committed direction for commutation logic |
| drive_inhibit | output | 1 | Hold all drives off while 1 |
| tach_req | output | 1 | One-cycle tachometer pulse request |

## Verification
On every cycle the assertions check that the holding stage tracks the synchronized direction when slow and stays frozen when fast, that the chain and the committed direction move only on PWM ticks, that the committed direction never changes unless the drives were inhibited the cycle before, and that the drives are enabled right after reset. The exact latency from a request to its commitment, the refusal of a reversal while fast followed by its later release, and the pairing of each toggle with one tachometer strobe are shown only by the bench's directed scenarios.

// File: rtl/dirrev_pkg.sv
package dirrev_pkg;

  // One-cycle change indication between a value and its delayed copy.
  function automatic logic level_changed(input logic now_v, input logic before_v);
    return now_v ^ before_v;
  endfunction

endpackage

// File: rtl/dirrev_sync.sv
module dirrev_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] ff_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_ff
      if (i == 0) begin : g_first
        always_ff @(posedge clk) ff_q[i] <= async_in;
      end else begin : g_next
        always_ff @(posedge clk) ff_q[i] <= ff_q[i-1];
      end
    end
  endgenerate

  assign sync_out = ff_q[STAGES-1];
endmodule

// File: rtl/dirrev_hold.sv
module dirrev_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic dir_s,
  input  logic speed_hi,
  output logic hold_q,
  output logic toggle_seen
);
  import dirrev_pkg::*;

  logic dir_prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q     <= dir_s;
      dir_prev_q <= dir_s;
    end else begin
      dir_prev_q <= dir_s;
      if (!speed_hi) hold_q <= dir_s;
    end
  end

  assign toggle_seen = level_changed(dir_s, dir_prev_q);

  a_r2_follow_when_slow: assert property (@(posedge clk) disable iff (!rst_n)
    !speed_hi |=> (hold_q == $past(dir_s)));

  a_r3_freeze_when_fast: assert property (@(posedge clk) disable iff (!rst_n)
    speed_hi |=> $stable(hold_q));
endmodule

// File: rtl/dirrev_chain.sv
module dirrev_chain #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dir_s,
  input  logic pwm_tick,
  input  logic chain_in,
  output logic chain_out,
  output logic chain_disagree
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] stage_q;
  logic [STAGES:0]   link;

  function automatic logic neighbours_differ(input logic [STAGES:0] v);
    return |(v[STAGES:1] ^ v[STAGES-1:0]);
  endfunction

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n)        stage_q[i] <= dir_s;
        else if (pwm_tick) stage_q[i] <= link[i];
      end
    end
  endgenerate

  assign link           = {stage_q, chain_in};
  assign chain_out      = stage_q[LAST];
  assign chain_disagree = neighbours_differ(link);

  a_r4_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_tick |=> $stable(stage_q));
endmodule

// File: rtl/dir_reversal_guard.sv
module dir_reversal_guard #(
  parameter int SYNC_STAGES  = 2,
  parameter int SHIFT_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dir_req,
  input  logic speed_hi,
  input  logic pwm_tick,
  output logic dir_commit,
  output logic drive_inhibit,
  output logic tach_req
);
  logic dir_s;
  logic hold_q;
  logic hold_disagree;
  logic chain_disagree;
  logic toggle_seen;

  dirrev_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .async_in (dir_req),
    .sync_out (dir_s)
  );

  dirrev_hold u_hold (
    .clk         (clk),
    .rst_n       (rst_n),
    .dir_s       (dir_s),
    .speed_hi    (speed_hi),
    .hold_q      (hold_q),
    .toggle_seen (toggle_seen)
  );

  dirrev_chain #(.STAGES(SHIFT_STAGES)) u_chain (
    .clk            (clk),
    .rst_n          (rst_n),
    .dir_s          (dir_s),
    .pwm_tick       (pwm_tick),
    .chain_in       (hold_q),
    .chain_out      (dir_commit),
    .chain_disagree (chain_disagree)
  );

  assign hold_disagree = dir_s ^ hold_q;
  assign drive_inhibit = hold_disagree | chain_disagree;
  assign tach_req      = toggle_seen;

  a_r4_commit_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dir_commit) |-> $past(pwm_tick));

  a_r6_commit_under_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dir_commit) |-> $past(drive_inhibit));

  a_r7_enabled_means_agree: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_inhibit |-> (dir_commit == hold_q));

  a_r9_clean_release: assert property (@(posedge clk)
    (rst_n && !$past(rst_n)) |-> (!drive_inhibit && !tach_req));
endmodule

// File: tb/dir_reversal_guard_bench.sv
module dir_reversal_guard_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dir_req = 1'b1;
  logic speed_hi = 1'b0;
  logic pwm_tick = 1'b0;
  logic dir_commit, drive_inhibit, tach_req;

  int n_checks = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  dir_reversal_guard u_dir_reversal_guard (
    .clk(clk), .rst_n(rst_n), .dir_req(dir_req), .speed_hi(speed_hi),
    .pwm_tick(pwm_tick), .dir_commit(dir_commit),
    .drive_inhibit(drive_inhibit), .tach_req(tach_req)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick();
    pwm_tick = 1'b1;
    cyc(1);
    pwm_tick = 1'b0;
  endtask

  task automatic expect3(input string req, input logic c, input logic inh, input logic t);
    n_checks++;
    if (dir_commit !== c || drive_inhibit !== inh || tach_req !== t) begin
      n_fail++;
      $display("FAIL %s: commit/inhibit/tach actual %b%b%b expected %b%b%b",
               req, dir_commit, drive_inhibit, tach_req, c, inh, t);
    end
  endtask

  task automatic t_reset();
    dir_req = 1'b1; rst_n = 1'b0;
    cyc(6);
    rst_n = 1'b1;
    cyc(1);
    expect3("R9 reset release", 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_slow_reverse();
    dir_req = 1'b0;
    cyc(1);
    expect3("R1 not yet synchronized", 1'b1, 1'b0, 1'b0);
    cyc(1);
    expect3("R8 R5 toggle strobe", 1'b1, 1'b1, 1'b1);
    cyc(1);
    expect3("R2 R6 held, strobe ends", 1'b1, 1'b1, 1'b0);
    cyc(3);
    expect3("R4 no tick no advance", 1'b1, 1'b1, 1'b0);
    tick();
    expect3("R4 R6 first tick", 1'b1, 1'b1, 1'b0);
    cyc(2);
    tick();
    expect3("R4 R7 second tick commits", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_fast_blocked();
    speed_hi = 1'b1; dir_req = 1'b1;
    cyc(2);
    expect3("R8 strobe while fast", 1'b0, 1'b1, 1'b1);
    cyc(1);
    for (int i = 0; i < 3; i++) tick();
    expect3("R3 R5 blocked while fast", 1'b0, 1'b1, 1'b0);
    speed_hi = 1'b0;
    cyc(1);
    expect3("R2 R6 accepted when slow", 1'b0, 1'b1, 1'b0);
    tick();
    tick();
    expect3("R4 R7 committed after slow", 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_fast_bounce();
    speed_hi = 1'b1; dir_req = 1'b0;
    cyc(2);
    expect3("R8 first bounce strobe", 1'b1, 1'b1, 1'b1);
    cyc(1);
    dir_req = 1'b1;
    cyc(2);
    expect3("R8 second bounce strobe", 1'b1, 1'b0, 1'b1);
    cyc(1);
    tick();
    expect3("R3 R7 bounce ignored", 1'b1, 1'b0, 1'b0);
    speed_hi = 1'b0;
  endtask

  task automatic t_idle_ticks();
    for (int i = 0; i < 4; i++) begin
      tick();
      expect3("R7 idle ticks", 1'b1, 1'b0, 1'b0);
    end
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_slow_reverse();
        t_fast_blocked();
        t_fast_bounce();
        t_idle_ticks();
      end
      begin
        cyc(5000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule